// File: doc/BRIEF.md
# Frame Sync Protection Counter

This block decides whether a received frame is aligned with a local frame-position counter. A frame carries four distinct block-identification codes at evenly spaced slots. An external detector reports each code it finds with a one-cycle strobe and a two-bit code number. The block compares that number with the slot position it predicts for that cycle. Runs of agreeing or disagreeing events drive a protection counter inside a four-state machine, and the machine raises or drops a sync flag.

Two thresholds shape the behaviour. The acquire threshold sets how many consistent code events are needed before sync is declared. The loss threshold sets how many consecutive disagreeing events are tolerated before sync is dropped. Each threshold is written through a small register port as the wanted count minus one. The position counter advances on its own once every `SLOT_LEN` cycles. It keeps running while codes are missing, so a locked receiver coasts through lost codes.

States: `ST_HUNT` (no candidate alignment), `ST_VERIFY` (counting consistent events after an anchor), `ST_LOCK` (in sync, no pending mismatch), `ST_HOLD` (in sync, counting mismatches). Transitions: HUNT→VERIFY on any code (anchor), or HUNT→LOCK on any code when the acquire count is 1. VERIFY→VERIFY on a mismatch, which re-anchors and restarts the count. VERIFY→LOCK on the match that reaches the acquire count. LOCK→HOLD on a mismatch, or LOCK→HUNT on a mismatch when the loss count is 1. HOLD→LOCK on any match. HOLD→HUNT on the mismatch that reaches the loss count.

Top module: `frame_sync_guard`

## Requirements
- R1: After reset `sync_o` is 0 and `frame_pos` is 0. The acquire count is 2 (stored value 1) and the loss count is 8 (stored value 7).
- R2: With no re-anchor, `frame_pos` advances by one every `SLOT_LEN` cycles, wrapping from 3 to 0.
- R3: Outside sync, a code event re-anchors the position: in the cycle after the strobe, `frame_pos` equals the detected code number.
- R4: Outside sync, sync is declared when the anchoring event plus the following consistent events reach the acquire count (stored value + 1).
- R5: While verifying, a code that disagrees with `frame_pos` restarts the count, with that code as the new anchor.
- R6: In sync, the loss count (stored value + 1) of consecutive mismatching code events drops sync and returns to hunting.
- R7: In sync, any matching code event clears the pending mismatch count.
- R8: A slot with no code strobe counts as neither match nor mismatch, and `frame_pos` keeps advancing through it.
- R9: A write with `reg_wr`=1 decodes only `reg_addr[3:0]`. Value 3 loads the acquire threshold and value 4 loads the loss threshold from `reg_wdata`. Any other low-nibble value changes nothing, and bits above bit 3 are ignored.
- R10: Reset restores both default thresholds and overwrites any programmed values.
- R11: `sync_o` is registered and changes only in the cycle after the code event that crosses a threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_vld | input | 1 | One-cycle strobe: a block code was detected |
| code_id | input | 2 | Number (0..3) of the detected code |
| reg_wr | input | 1 | Threshold register write strobe |
| reg_addr | input | ADDR_W | Register address, low nibble decoded |
| reg_wdata | input | PROT_W | Threshold value (wanted count minus one) |
| sync_o | output | 1 | Frame sync declared |
| frame_pos | output | 2 | Predicted code position for the current slot |

## Verification
The bench builds the block with `SLOT_LEN` = 4 and leaves the threshold width, address width and default counts at their defaults. The short slot lets whole frames, including position wraps and coasting through missing codes, fit into a few dozen cycles. Keeping the default counts lets the reset defaults be seen directly. Both thresholds are then reprogrammed to a count of 3, which makes the re-anchor, mismatch-clear and loss paths each reachable within a handful of slots.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    localparam int CODE_W    = 2;
    localparam int NUM_CODES = 4;

    localparam logic [3:0] ADDR_ACQ  = 4'h3;
    localparam logic [3:0] ADDR_LOSS = 4'h4;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_VERIFY,
        ST_LOCK,
        ST_HOLD
    } fsg_state_e;
endpackage

// File: rtl/fsg_thresholds.sv
module fsg_thresholds #(
    parameter int                PROT_W   = 4,
    parameter int                ADDR_W   = 8,
    parameter logic [PROT_W-1:0] ACQ_RST  = 1,
    parameter logic [PROT_W-1:0] LOSS_RST = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [PROT_W-1:0] reg_wdata,
    output logic [PROT_W-1:0] acq_thr,
    output logic [PROT_W-1:0] loss_thr
);
    import fsg_pkg::*;

    logic [3:0] sel;
    logic       unused_addr_hi;

    assign sel            = reg_addr[3:0];
    assign unused_addr_hi = ^reg_addr[ADDR_W-1:4];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acq_thr  <= ACQ_RST;
            loss_thr <= LOSS_RST;
        end else if (reg_wr) begin
            if (sel == ADDR_ACQ)  acq_thr  <= reg_wdata;
            if (sel == ADDR_LOSS) loss_thr <= reg_wdata;
        end
    end
endmodule

// File: rtl/fsg_frame_ctr.sv
module fsg_frame_ctr #(
    parameter int SLOT_LEN = 272
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      realign,
    input  logic [fsg_pkg::CODE_W-1:0] anchor_code,
    output logic [fsg_pkg::CODE_W-1:0] pos
);
    import fsg_pkg::*;

    generate
        if (SLOT_LEN == 1) begin : g_per_cycle
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       pos <= '0;
                else if (realign) pos <= anchor_code + CODE_W'(1);
                else              pos <= pos + CODE_W'(1);
            end
        end else begin : g_timed
            localparam int TW = $clog2(SLOT_LEN);
            logic [TW-1:0] tick;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tick <= '0;
                    pos  <= '0;
                end else if (realign) begin
                    tick <= TW'(1);
                    pos  <= anchor_code;
                end else if (tick == TW'(SLOT_LEN - 1)) begin
                    tick <= '0;
                    pos  <= pos + CODE_W'(1);
                end else begin
                    tick <= tick + TW'(1);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/fsg_ctrl.sv
module fsg_ctrl #(
    parameter int PROT_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       code_vld,
    input  logic [fsg_pkg::CODE_W-1:0] code_id,
    input  logic [fsg_pkg::CODE_W-1:0] pos,
    input  logic [PROT_W-1:0]          acq_thr,
    input  logic [PROT_W-1:0]          loss_thr,
    output logic                       sync,
    output logic                       realign
);
    import fsg_pkg::*;

    localparam int CNT_W = PROT_W + 1;

    fsg_state_e state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             hit;
    logic             acq_done, loss_done;

    assign hit       = (code_id == pos);
    assign acq_done  = (cnt >= {1'b0, acq_thr});
    assign loss_done = (cnt >= {1'b0, loss_thr});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HUNT;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_HUNT: begin
                if (code_vld) begin
                    if (acq_thr == '0) begin
                        state_nxt = ST_LOCK;
                        cnt_nxt   = '0;
                    end else begin
                        state_nxt = ST_VERIFY;
                        cnt_nxt   = CNT_W'(1);
                    end
                end
            end
            ST_VERIFY: begin
                if (code_vld) begin
                    if (!hit) begin
                        cnt_nxt = CNT_W'(1);
                    end else if (acq_done) begin
                        state_nxt = ST_LOCK;
                        cnt_nxt   = '0;
                    end else begin
                        cnt_nxt = cnt + CNT_W'(1);
                    end
                end
            end
            ST_LOCK: begin
                if (code_vld && !hit) begin
                    if (loss_thr == '0) begin
                        state_nxt = ST_HUNT;
                        cnt_nxt   = '0;
                    end else begin
                        state_nxt = ST_HOLD;
                        cnt_nxt   = CNT_W'(1);
                    end
                end
            end
            ST_HOLD: begin
                if (code_vld) begin
                    if (hit) begin
                        state_nxt = ST_LOCK;
                        cnt_nxt   = '0;
                    end else if (loss_done) begin
                        state_nxt = ST_HUNT;
                        cnt_nxt   = '0;
                    end else begin
                        cnt_nxt = cnt + CNT_W'(1);
                    end
                end
            end
        endcase
    end

    always_comb begin
        sync    = (state == ST_LOCK) || (state == ST_HOLD);
        realign = code_vld &&
                  ((state == ST_HUNT) || ((state == ST_VERIFY) && !hit));
    end
endmodule

// File: rtl/frame_sync_guard.sv
module frame_sync_guard #(
    parameter int SLOT_LEN       = 272,
    parameter int PROT_W         = 4,
    parameter int ADDR_W         = 8,
    parameter int ACQ_COUNT_DEF  = 2,
    parameter int LOSS_COUNT_DEF = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_vld,
    input  logic [1:0]        code_id,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [PROT_W-1:0] reg_wdata,
    output logic              sync_o,
    output logic [1:0]        frame_pos
);
    localparam logic [PROT_W-1:0] ACQ_RST  = PROT_W'(ACQ_COUNT_DEF - 1);
    localparam logic [PROT_W-1:0] LOSS_RST = PROT_W'(LOSS_COUNT_DEF - 1);

    logic [PROT_W-1:0] acq_thr;
    logic [PROT_W-1:0] loss_thr;
    logic              realign_w;

    fsg_thresholds #(
        .PROT_W  (PROT_W),
        .ADDR_W  (ADDR_W),
        .ACQ_RST (ACQ_RST),
        .LOSS_RST(LOSS_RST)
    ) u_thr (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .acq_thr  (acq_thr),
        .loss_thr (loss_thr)
    );

    fsg_frame_ctr #(
        .SLOT_LEN(SLOT_LEN)
    ) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .realign    (realign_w),
        .anchor_code(code_id),
        .pos        (frame_pos)
    );

    fsg_ctrl #(
        .PROT_W(PROT_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .code_vld(code_vld),
        .code_id (code_id),
        .pos     (frame_pos),
        .acq_thr (acq_thr),
        .loss_thr(loss_thr),
        .sync    (sync_o),
        .realign (realign_w)
    );
endmodule

// File: rtl/frame_sync_guard_chk.sv
module frame_sync_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       code_vld,
    input logic [1:0] code_id,
    input logic [1:0] frame_pos,
    input logic       sync_o,
    input logic       realign
);
    // R1: the cycle after a reset edge shows the cleared outputs
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!sync_o && frame_pos == 2'd0));

    // R2: without a re-anchor the position only steps forward by one
    p_pos_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pos != $past(frame_pos) && !$past(realign))
            |-> frame_pos == $past(frame_pos) + 2'd1);

    // R4: sync is only gained right after a code event
    p_rise_on_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |-> $past(code_vld));

    // R6: sync is only lost right after a mismatching code event
    p_fall_on_mismatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_o) |-> ($past(code_vld) && $past(code_id) != $past(frame_pos)));

    // R8: a cycle without a code leaves the sync flag alone
    p_quiet_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(code_vld) |-> $stable(sync_o));
endmodule

bind frame_sync_guard frame_sync_guard_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .code_vld (code_vld),
    .code_id  (code_id),
    .frame_pos(frame_pos),
    .sync_o   (sync_o),
    .realign  (realign_w)
);

// File: tb/test_frame_sync_guard.sv
module test_frame_sync_guard;
    localparam int SLOT_LEN = 4;
    localparam int NVEC     = 15;

    // each entry: {strobe, code[1:0], expected sync after the slot}
    // thresholds during the table: acquire count 3, loss count 3
    localparam logic [3:0] VEC [NVEC] = '{
        4'b1_00_0,  // anchor 0
        4'b1_01_0,  // consistent, count 2
        4'b1_11_0,  // R5 mismatch, re-anchor on 3
        4'b1_00_0,  // count 2
        4'b0_00_0,  // R8 missing code, pos coasts to 1
        4'b1_10_1,  // R4 third consistent event -> sync
        4'b1_10_1,  // mismatch 1
        4'b1_00_1,  // R7 match clears pending mismatch
        4'b1_11_1,  // mismatch 1
        4'b1_11_1,  // mismatch 2
        4'b0_00_1,  // R8 missing code is not a mismatch
        4'b1_01_0,  // R6 mismatch 3 -> lost
        4'b1_10_0,  // anchor 2
        4'b1_11_0,  // count 2
        4'b1_00_1   // count 3 -> sync
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       code_vld = 1'b0;
    logic [1:0] code_id = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'd0;
    logic [3:0] reg_wdata = 4'd0;
    logic       sync_o;
    logic [1:0] frame_pos;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    frame_sync_guard #(.SLOT_LEN(SLOT_LEN)) i_frame_sync_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .code_vld (code_vld),
        .code_id  (code_id),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .sync_o   (sync_o),
        .frame_pos(frame_pos)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [3:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // one slot: drive optional strobe, return one cycle after its edge
    task automatic send_slot(input logic v, input logic [1:0] c);
        repeat (SLOT_LEN - 1) @(negedge clk);
        code_vld = v; code_id = c;
        @(negedge clk);
        code_vld = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [1:0] e;

        // reset state and free-running position
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 sync after reset", sync_o, 0);
        chk("R1 pos after reset", frame_pos, 0);
        repeat (SLOT_LEN) @(negedge clk);
        chk("R2 pos after one slot", frame_pos, 1);
        repeat (3 * SLOT_LEN) @(negedge clk);
        chk("R2 pos wraps to 0", frame_pos, 0);

        // default acquire count 2
        send_slot(1'b1, 2'd2);
        chk("R3 pos re-anchored", frame_pos, 2);
        chk("R1 default acquire, one event", sync_o, 0);
        send_slot(1'b1, 2'd3);
        chk("R11 sync raised right after edge", sync_o, 1);

        // default loss count 8
        e = 2'd0;
        for (int k = 0; k < 7; k++) begin
            send_slot(1'b1, e + 2'd2);
            chk("R1 default loss, still held", sync_o, 1);
            e = e + 2'd1;
        end
        send_slot(1'b1, e + 2'd2);
        chk("R1 default loss, eighth mismatch", sync_o, 0);

        // program counts of 3; upper address bits set on one write,
        // an undecoded address carries a value that would break the table
        wr_reg(8'hF3, 4'd2);
        wr_reg(8'h04, 4'd2);
        wr_reg(8'h05, 4'd0);

        for (int i = 0; i < NVEC; i++) begin
            send_slot(VEC[i][3], VEC[i][2:1]);
            chk($sformatf("R4 R5 R6 R7 R8 R9 table step %0d", i),
                sync_o, int'(VEC[i][0]));
        end
        chk("R8 pos coasting in sync", frame_pos, 0);

        // R10: reset brings back the default acquire count 2
        do_reset();
        chk("R10 sync cleared", sync_o, 0);
        send_slot(1'b1, 2'd1);
        send_slot(1'b1, 2'd2);
        chk("R10 default acquire restored", sync_o, 1);

        finish_run();
    end
endmodule